// File: doc/BRIEF.md
# Sixteen-Channel Discriminator Pulse Shaper

This block sits behind sixteen comparator channels. For each channel it turns a synchronous trigger strobe into one standard output pulse. When a channel takes a trigger, it first runs a dead interval. It then raises its output for a set width and returns to idle. While a channel is in either phase it cannot take a new trigger. The dead interval and the width are set by two global 4-bit codes that come from a register block. Code n gives (n+1)·K clock cycles, where K is the parameter `STEP_CYCLES`.

A per-channel mask and a global veto keep channels from taking triggers. A test strobe gives every channel that is allowed to fire a trigger at the same moment. Two summary outputs follow the live pulses: a wide OR, and a 5-bit count of the channels whose pulse is high.

Top module: `discShaper16`

## Requirements
- R1: Channel i takes a trigger at a clock edge when all of these hold at that edge: `trigIn[i]` is 1 and was 0 at the previous edge, the channel is idle, `maskIn[i]` is 0 and `vetoIn` is 0. The channels act independently of one another.
- R2: If a trigger is taken at edge E0, `pulseOut[i]` goes high after edge E0+(d+1)·K. It then stays high for exactly (w+1)·K cycles. Here d and w are the dead and width codes and K is `STEP_CYCLES`. The pulse never starts without a dead interval first.
- R3: The dead code and the width code are captured at the edge where the trigger is taken. Changing either code later does not change a pulse that is already in progress.
- R4: Each event produces exactly one pulse. An input held high gives no further pulses. Rising edges that arrive during the dead or width phase are dropped.
- R5: A channel whose `maskIn` bit is 1 takes no trigger, whether it comes from its own input or from the test strobe. Any mix of channels can be masked at once.
- R6: While `vetoIn` is 1, no channel takes a trigger. Pulses already in progress run to completion.
- R7: A rising edge of `testIn` (1 now, 0 at the previous edge) acts as a trigger on all sixteen channels at once, under the same conditions as R1.
- R8: `orOut` is 1 exactly when at least one bit of `pulseOut` is 1.
- R9: `fireCount` equals the number of `pulseOut` bits that are 1, from 0 to 16, as an unsigned binary value.
- R10: While `rstN` is low, all channels are idle and all outputs are 0. The stored input history is also cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| trigIn | input | 16 | Per-channel trigger strobes, rising edge active |
| maskIn | input | 16 | Per-channel inhibit, 1 blocks the channel |
| vetoIn | input | 1 | Global inhibit of new triggers |
| testIn | input | 1 | Test fire of all enabled channels, rising edge active |
| deadCode | input | 4 | Dead interval code, length (code+1)·K cycles |
| widthCode | input | 4 | Output width code, length (code+1)·K cycles |
| pulseOut | output | 16 | Per-channel output pulses |
| orOut | output | 1 | OR of all output pulses |
| fireCount | output | 5 | Number of channels whose pulse is high |

## Verification
The hardest state to reach from the ports is a code change that lands while a channel is partway through its dead or width phase. Close behind it is a rising edge that reaches a busy channel just before that channel returns to idle. The stimulus reaches the first case by firing a channel and rewriting both codes a few cycles later. It reaches the second by holding an input high across a whole pulse and toggling other inputs at random intervals. A cycle-level reference model in the bench follows every channel's phase, so edges that hit the boundary of a phase are checked on every cycle.

// File: rtl/discPkg.sv
package discPkg;
  parameter int CH_N   = 16;
  parameter int CODE_W = 4;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_DEAD  = 2'd1,
    PH_WIDTH = 2'd2
  } phase_t;

  // strobes from control to timer datapath, one bit per channel
  typedef struct packed {
    logic [CH_N-1:0] loadDead;
    logic [CH_N-1:0] loadWidth;
    logic [CH_N-1:0] run;
  } timerCtl_t;
endpackage

// File: rtl/discChanCtrl.sv
module discChanCtrl
  import discPkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic [CH_N-1:0] trigIn,
  input  logic [CH_N-1:0] maskIn,
  input  logic            vetoIn,
  input  logic            testIn,
  input  logic [CH_N-1:0] expired,
  output timerCtl_t       tctl,
  output logic [CH_N-1:0] pulse,
  output logic [CH_N-1:0] busy
);
  logic [CH_N-1:0] trigPrev;
  logic            testPrev;
  logic            testRise;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trigPrev <= '0;
      testPrev <= 1'b0;
    end else begin
      trigPrev <= trigIn;
      testPrev <= testIn;
    end
  end

  assign testRise = testIn & ~testPrev;

  for (genvar c = 0; c < CH_N; c++) begin : g_chan
    phase_t phase, phaseNext;
    logic   accept;

    assign accept = (phase == PH_IDLE) & ~maskIn[c] & ~vetoIn
                  & ((trigIn[c] & ~trigPrev[c]) | testRise);

    always_comb begin
      phaseNext           = phase;
      tctl.loadDead[c]    = 1'b0;
      tctl.loadWidth[c]   = 1'b0;
      unique case (phase)
        PH_IDLE: if (accept) begin
          phaseNext        = PH_DEAD;
          tctl.loadDead[c] = 1'b1;
        end
        PH_DEAD: if (expired[c]) begin
          phaseNext         = PH_WIDTH;
          tctl.loadWidth[c] = 1'b1;
        end
        PH_WIDTH: if (expired[c]) phaseNext = PH_IDLE;
        default: phaseNext = PH_IDLE;
      endcase
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) phase <= PH_IDLE;
      else       phase <= phaseNext;
    end

    assign tctl.run[c] = (phase != PH_IDLE);
    assign pulse[c]    = (phase == PH_WIDTH);
    assign busy[c]     = (phase != PH_IDLE);
  end
endmodule

// File: rtl/discTimerBank.sv
module discTimerBank
  import discPkg::*;
#(
  parameter int STEP_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  timerCtl_t         tctl,
  input  logic [CODE_W-1:0] deadCode,
  input  logic [CODE_W-1:0] widthCode,
  output logic [CH_N-1:0]   expired
);
  localparam int MAX_LEN = (1 << CODE_W) * STEP_CYCLES;
  localparam int CNT_W   = (MAX_LEN > 2) ? $clog2(MAX_LEN) : 1;

  function automatic logic [CNT_W-1:0] lenOf(input logic [CODE_W-1:0] code);
    int unsigned len;
    len = (int'(code) + 1) * STEP_CYCLES - 1;
    return CNT_W'(len);
  endfunction

  for (genvar c = 0; c < CH_N; c++) begin : g_tmr
    logic [CNT_W-1:0]  cnt;
    logic [CODE_W-1:0] widthHeld;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cnt       <= '0;
        widthHeld <= '0;
      end else if (tctl.loadDead[c]) begin
        cnt       <= lenOf(deadCode);
        widthHeld <= widthCode;
      end else if (tctl.loadWidth[c]) begin
        cnt <= lenOf(widthHeld);
      end else if (tctl.run[c] && cnt != '0) begin
        cnt <= cnt - 1'b1;
      end
    end

    assign expired[c] = (cnt == '0);
  end
endmodule

// File: rtl/discFireTally.sv
module discFireTally
  import discPkg::*;
#(
  parameter int SUM_W = $clog2(CH_N + 1)
) (
  input  logic [CH_N-1:0]  pulse,
  output logic             anyFire,
  output logic [SUM_W-1:0] fireSum
);
  logic [SUM_W-1:0] partial [CH_N+1];

  assign partial[0] = '0;
  for (genvar c = 0; c < CH_N; c++) begin : g_add
    assign partial[c+1] = partial[c] + SUM_W'(pulse[c]);
  end

  assign fireSum = partial[CH_N];
  assign anyFire = |pulse;
endmodule

// File: rtl/discShaper16.sv
module discShaper16
  import discPkg::*;
#(
  parameter int STEP_CYCLES = 4,
  localparam int SUM_W = $clog2(CH_N + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CH_N-1:0]   trigIn,
  input  logic [CH_N-1:0]   maskIn,
  input  logic              vetoIn,
  input  logic              testIn,
  input  logic [CODE_W-1:0] deadCode,
  input  logic [CODE_W-1:0] widthCode,
  output logic [CH_N-1:0]   pulseOut,
  output logic              orOut,
  output logic [SUM_W-1:0]  fireCount
);
  timerCtl_t       tctl;
  logic [CH_N-1:0] expired;
  logic [CH_N-1:0] chanBusy;

  discChanCtrl i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .trigIn  (trigIn),
    .maskIn  (maskIn),
    .vetoIn  (vetoIn),
    .testIn  (testIn),
    .expired (expired),
    .tctl    (tctl),
    .pulse   (pulseOut),
    .busy    (chanBusy)
  );

  discTimerBank #(.STEP_CYCLES(STEP_CYCLES)) i_tmr (
    .clk       (clk),
    .rstN      (rstN),
    .tctl      (tctl),
    .deadCode  (deadCode),
    .widthCode (widthCode),
    .expired   (expired)
  );

  discFireTally #(.SUM_W(SUM_W)) i_tally (
    .pulse   (pulseOut),
    .anyFire (orOut),
    .fireSum (fireCount)
  );
endmodule

// File: rtl/discShaperChk.sv
module discShaperChk
  import discPkg::*;
#(
  parameter int SUM_W = $clog2(CH_N + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic [CH_N-1:0]  pulseOut,
  input logic             orOut,
  input logic [SUM_W-1:0] fireCount,
  input logic [CH_N-1:0]  maskIn,
  input logic             vetoIn,
  input logic [CH_N-1:0]  busy
);
  // R8
  or_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    orOut == (pulseOut != '0));

  // R9
  count_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    int'(fireCount) == $countones(pulseOut));

  // R5
  mask_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((busy & ~$past(busy)) & $past(maskIn)) == '0);

  // R6
  veto_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    vetoIn |=> ((busy & ~$past(busy)) == '0));

  // R2
  dead_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((pulseOut & ~$past(pulseOut)) & ~$past(busy)) == '0);

  // R10
  reset_idle_chk: assert property (@(posedge clk)
    !rstN |-> (pulseOut == '0 && fireCount == '0 && !orOut));
endmodule

bind discShaper16 discShaperChk #(.SUM_W(SUM_W)) i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .pulseOut  (pulseOut),
  .orOut     (orOut),
  .fireCount (fireCount),
  .maskIn    (maskIn),
  .vetoIn    (vetoIn),
  .busy      (chanBusy)
);

// File: tb/test_discShaper16.sv
module test_discShaper16;
  localparam int K = 4;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] trigIn = '0;
  logic [15:0] maskIn = '0;
  logic        vetoIn = 1'b0;
  logic        testIn = 1'b0;
  logic [3:0]  deadCode = '0;
  logic [3:0]  widthCode = '0;
  logic [15:0] pulseOut;
  logic        orOut;
  logic [4:0]  fireCount;

  int errors = 0;
  int checks = 0;
  string curReq = "R10";

  // reference model state
  int ph [N];
  int rem [N];
  int wl [N];
  logic [15:0] prevTrig = '0;
  logic        prevTest = 1'b0;

  always #10 clk = ~clk;

  discShaper16 #(.STEP_CYCLES(K)) i_discShaper16 (
    .clk(clk), .rstN(rstN), .trigIn(trigIn), .maskIn(maskIn),
    .vetoIn(vetoIn), .testIn(testIn), .deadCode(deadCode),
    .widthCode(widthCode), .pulseOut(pulseOut), .orOut(orOut),
    .fireCount(fireCount)
  );

  function automatic logic [15:0] expPulse();
    logic [15:0] v = '0;
    for (int c = 0; c < N; c++) v[c] = (ph[c] == 2);
    return v;
  endfunction

  function automatic int ones(input logic [15:0] v);
    int n = 0;
    for (int c = 0; c < N; c++) n += v[c];
    return n;
  endfunction

  task automatic modelEdge();
    logic tRise;
    if (!rstN) begin
      for (int c = 0; c < N; c++) begin ph[c] = 0; rem[c] = 0; wl[c] = 0; end
      prevTrig = '0;
      prevTest = 1'b0;
      return;
    end
    tRise = testIn & ~prevTest;
    for (int c = 0; c < N; c++) begin
      if (ph[c] != 0) begin
        rem[c]--;
        if (rem[c] == 0) begin
          if (ph[c] == 1) begin ph[c] = 2; rem[c] = (wl[c] + 1) * K; end
          else ph[c] = 0;
        end
      end else if (!maskIn[c] && !vetoIn && ((trigIn[c] && !prevTrig[c]) || tRise)) begin
        ph[c] = 1; rem[c] = (int'(deadCode) + 1) * K; wl[c] = int'(widthCode);
      end
    end
    prevTrig = trigIn;
    prevTest = testIn;
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // one clock: model follows the edge, outputs sampled at the falling edge
  task automatic step();
    logic [15:0] e;
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    e = expPulse();
    check({curReq, " pulseOut"}, int'(pulseOut), int'(e));
    check("R8 orOut", int'(orOut), int'(e != '0));
    check("R9 fireCount", int'(fireCount), ones(e));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  bit done = 0;
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int wsave, width0, rises;
    void'($urandom(32'h5eed1234));
    // R10 reset
    curReq = "R10";
    idle(3);
    check("R10 reset pulse", int'(pulseOut), 0);
    rstN = 1'b1;
    idle(2);

    // R1 R2: single channel, minimum then maximum codes
    curReq = "R2";
    deadCode = 4'd0; widthCode = 4'd0; trigIn[0] = 1'b1; step();
    trigIn[0] = 1'b0; idle(3 * K);
    deadCode = 4'd15; widthCode = 4'd15; trigIn[5] = 1'b1; step();
    trigIn[5] = 1'b0; idle(33 * K);
    curReq = "R1";
    deadCode = 4'd2; widthCode = 4'd1; trigIn = 16'hA5A5; step();
    trigIn = 16'h5A5A; step(); trigIn = '0; idle(8 * K);

    // R3: codes changed mid-pulse
    curReq = "R3";
    deadCode = 4'd1; widthCode = 4'd3; wsave = (3 + 1) * K;
    trigIn[3] = 1'b1; step(); trigIn[3] = 1'b0;
    idle(2); deadCode = 4'd9; widthCode = 4'd0;
    width0 = 0;
    for (int i = 0; i < 12 * K; i++) begin step(); width0 += pulseOut[3]; end
    check("R3 held width", width0, wsave);

    // R4: input held high over several pulse periods
    curReq = "R4";
    deadCode = 4'd0; widthCode = 4'd0; rises = 0;
    trigIn[7] = 1'b1;
    for (int i = 0; i < 10 * K; i++) begin
      logic was;
      was = pulseOut[7];
      step();
      if (pulseOut[7] && !was) rises++;
      if (i == 3) trigIn[8] = 1'b1;
      if (i == 4) trigIn[8] = 1'b0;
      if (i == 5) trigIn[8] = 1'b1;
    end
    check("R4 single pulse", rises, 1);
    trigIn = '0; idle(4 * K);

    // R5 R7: test fire with mask pattern
    curReq = "R7";
    maskIn = 16'h0F0F; testIn = 1'b1; step(); testIn = 1'b0;
    idle(3 * K);
    curReq = "R5";
    check("R5 masked idle", int'(pulseOut & maskIn), 0);
    maskIn = 16'hFFFF; trigIn = 16'hFFFF; testIn = 1'b1; step();
    trigIn = '0; testIn = 1'b0; idle(3 * K);
    check("R5 all masked", int'(pulseOut), 0);
    maskIn = '0;

    // R6: veto blocks new triggers, pulses in progress continue
    curReq = "R6";
    trigIn[2] = 1'b1; step(); trigIn[2] = 1'b0;
    vetoIn = 1'b1; trigIn[9] = 1'b1; testIn = 1'b1; step();
    trigIn[9] = 1'b0; testIn = 1'b0; idle(3 * K);
    vetoIn = 1'b0; idle(2 * K);

    // random mix
    curReq = "R1 R4 R5 R6 R7";
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 3) == 0) trigIn = 16'($urandom());
      if ($urandom_range(0, 15) == 0) maskIn = 16'($urandom()) & 16'($urandom());
      vetoIn = ($urandom_range(0, 9) == 0);
      testIn = ($urandom_range(0, 40) == 0);
      if ($urandom_range(0, 60) == 0) begin
        deadCode = 4'($urandom_range(0, 3)); widthCode = 4'($urandom_range(0, 3));
      end
      step();
    end
    trigIn = '0; vetoIn = 1'b0; testIn = 1'b0; idle(40 * K);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule